// File: doc/BRIEF.md
# E1 Timeslot Signaling Serializer

This block drives a serial signaling line that runs bit-for-bit beside a 32-timeslot E1 data line. A host keeps a small table with one 4-bit signaling nibble per channel. While a channel's data byte is on the data line, the block shifts that channel's nibble onto the signaling line and raises a valid flag for those bit periods. For the rest of the timeslot the flag is low and the line is held low.

The block does no framing and gives no timeslot special treatment. Timeslot 0 and timeslot 16 each carry their own stored nibble, like every other slot. The whole table is sent again in every frame.

A frame-start pulse aligns the block to the data path. Between pulses it runs free and wraps at the end of each 256-bit frame. Each slot's nibble is latched at the start of that slot, so a host write never tears a nibble that is being sent.

Top module: `e1_cas_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, the block sits at timeslot 0, bit 0, with every stored nibble cleared. It therefore shows `sig_valid_o`=1 and `sig_o`=0.
- R2: Without a frame-start pulse, bit position 7 of a timeslot is followed by bit 0 of the next timeslot. Timeslot 31, bit 7 is followed by timeslot 0, bit 0, so a frame is 256 clock periods long.
- R3: When `frame_start_i` is sampled high at an edge, the cycle after that edge is timeslot 0, bit 0. This also holds when the pulse arrives where the counters would have wrapped anyway.
- R4: In bit periods 0 to 3 of a timeslot, `sig_o` carries the nibble latched for that slot, most significant bit first. The host data bit 3 is the first bit sent (A), and bit 0 is the fourth (D).
- R5: `sig_valid_o` is 1 in bit periods 0 to 3 and 0 in bit periods 4 to 7. Whenever `sig_valid_o` is 0, `sig_o` is 0.
- R6: Timeslots 0 and 16 are not special: each sends its own stored nibble, the same as the other 30 slots.
- R7: A write (`host_we_i`=1 at an edge) changes the table entry at that edge. The nibble sent in a slot is the table entry as it stood just before the edge that begins that slot. A write during a slot, or at the edge that begins it, is first sent in the following frame.
- R8: With no writes, every frame sends the same nibble in each slot.
- R9: A frame-start pulse in the middle of a frame realigns at once. Timeslot 0 starts in the next cycle and sends the stored nibble of slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start_i | input | 1 | Frame alignment pulse; the next cycle is timeslot 0, bit 0 |
| host_we_i | input | 1 | Table write enable |
| host_addr_i | input | 5 | Timeslot whose nibble is written |
| host_nib_i | input | 4 | Nibble to store; bit 3 is sent first |
| sig_o | output | 1 | Serial signaling bit |
| sig_valid_o | output | 1 | High while `sig_o` carries a signaling bit |

## Verification
The assertions check on every cycle:
- the counter stepping, the wrap and the frame-start alignment;
- that the output stays low outside the valid window;
- that the latched nibble cannot change in the middle of a slot;
- that a write lands in the addressed table entry.

Only the bench's scenarios can show that the right bits leave in the right order. It sweeps every slot over several whole frames against an arithmetic model. It also places writes in the middle of a slot and exactly on a slot-start edge. It fires frame-start pulses both mid-frame and on the natural frame boundary.

// File: rtl/cas_pkg.sv
// Package: shared types for the E1 signaling serializer.
// Assumes: nothing beyond IEEE 1800-2017.
package cas_pkg;
    // Phase of the bit period inside one timeslot.
    typedef enum logic {
        PH_SIG  = 1'b0,
        PH_IDLE = 1'b1
    } cas_phase_e;
endpackage

// File: rtl/cas_slot_timer.sv
// Module: cas_slot_timer
// Tracks the current timeslot and bit position of the frame.
// Also gives the position of the next cycle, so that the nibble latch can
// load exactly at a slot start.
// Assumes: NUM_SLOTS and SLOT_BITS are at least 2.
module cas_slot_timer #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_BITS = 8,
    localparam int SW = $clog2(NUM_SLOTS),
    localparam int BW = $clog2(SLOT_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start_i,
    output logic [SW-1:0] slot_o,
    output logic [BW-1:0] bit_o,
    output logic [SW-1:0] nxt_slot_o,
    output logic          nxt_start_o
);
    localparam logic [SW-1:0] LAST_SLOT = SW'(NUM_SLOTS - 1);
    localparam logic [BW-1:0] LAST_BIT  = BW'(SLOT_BITS - 1);

    logic [SW-1:0] slot_q, slot_d;
    logic [BW-1:0] bit_q, bit_d;

    // Next position: alignment first, then the bit step and the slot wrap.
    always_comb begin
        if (frame_start_i) begin
            slot_d = '0;
            bit_d  = '0;
        end else if (bit_q == LAST_BIT) begin
            bit_d  = '0;
            slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + SW'(1);
        end else begin
            bit_d  = bit_q + BW'(1);
            slot_d = slot_q;
        end
    end

    // Position registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= '0;
        end else begin
            slot_q <= slot_d;
            bit_q  <= bit_d;
        end
    end

    assign slot_o      = slot_q;
    assign bit_o       = bit_q;
    assign nxt_slot_o  = slot_d;
    assign nxt_start_o = (bit_d == '0);

    // R2: bit step within a slot keeps the slot.
    p_bit_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start_i && bit_q != LAST_BIT) |=>
            (bit_q == $past(bit_q) + BW'(1)) && $stable(slot_q));

    // R2: end of frame wraps to the start.
    p_frame_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start_i && bit_q == LAST_BIT && slot_q == LAST_SLOT) |=>
            (slot_q == '0 && bit_q == '0));

    // R3: the alignment pulse lands on slot 0, bit 0.
    p_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start_i |=> (slot_q == '0 && bit_q == '0));
endmodule

// File: rtl/cas_nibble_store.sv
// Module: cas_nibble_store
// Holds one signaling nibble per timeslot, written by the host.
// A separate latch takes the entry of the slot that is about to start, so
// a write never reaches a nibble that is already being sent.
// Assumes: load_addr_i and wr_addr_i are below DEPTH.
module cas_nibble_store #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 4,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             load_i,
    input  logic [AW-1:0]    load_addr_i,
    output logic [WIDTH-1:0] nib_o
);
    logic [WIDTH-1:0] ent_q [DEPTH];
    logic [WIDTH-1:0] nib_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        // One table entry: cleared by reset, replaced on an addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= '0;
            end else if (wr_en_i && wr_addr_i == AW'(g)) begin
                ent_q[g] <= wr_data_i;
            end
        end
    end

    // Slot-start latch: reads the table before any write at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nib_q <= '0;
        end else if (load_i) begin
            nib_q <= ent_q[load_addr_i];
        end
    end

    assign nib_o = nib_q;

    // R7: a write is stored in the addressed entry.
    p_write_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (ent_q[$past(wr_addr_i)] == $past(wr_data_i)));

    // R7: the latch only moves when a load was requested.
    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(nib_q));
endmodule

// File: rtl/cas_bit_driver.sv
// Module: cas_bit_driver
// Picks the serial bit out of the latched nibble for the current bit
// position. The most significant bit goes out first. Bit positions past the
// nibble are marked invalid and driven low.
// Assumes: SIG_BITS <= SLOT_BITS.
module cas_bit_driver #(
    parameter int SLOT_BITS = 8,
    parameter int SIG_BITS  = 4,
    localparam int BW = $clog2(SLOT_BITS)
) (
    input  logic [SIG_BITS-1:0] nib_i,
    input  logic [BW-1:0]       bit_i,
    output logic                sig_o,
    output logic                valid_o
);
    import cas_pkg::*;

    cas_phase_e phase;
    logic       pick;

    // Phase decode: the first SIG_BITS periods carry signaling.
    always_comb begin
        phase = (32'(bit_i) < SIG_BITS) ? PH_SIG : PH_IDLE;
    end

    // Bit selection, most significant bit first.
    always_comb begin
        pick = 1'b0;
        for (int k = 0; k < SIG_BITS; k++) begin
            if (bit_i == BW'(k)) pick = nib_i[SIG_BITS-1-k];
        end
    end

    assign valid_o = (phase == PH_SIG);
    assign sig_o   = (phase == PH_SIG) ? pick : 1'b0;
endmodule

// File: rtl/e1_cas_serializer.sv
// Module: e1_cas_serializer (top)
// Sends one stored signaling nibble per timeslot, in step with an E1 frame
// of NUM_SLOTS slots of SLOT_BITS bits each.
// Assumes: frame_start_i is synchronous to clk; the host port is in the
// same clock domain.
module e1_cas_serializer #(
    parameter int NUM_SLOTS = 32,
    parameter int SLOT_BITS = 8,
    parameter int SIG_BITS  = 4,
    localparam int SLOT_AW  = $clog2(NUM_SLOTS),
    localparam int BIT_W    = $clog2(SLOT_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start_i,
    input  logic                host_we_i,
    input  logic [SLOT_AW-1:0]  host_addr_i,
    input  logic [SIG_BITS-1:0] host_nib_i,
    output logic                sig_o,
    output logic                sig_valid_o
);
    logic [SLOT_AW-1:0]  slot_cur;
    logic [BIT_W-1:0]    bit_cur;
    logic [SLOT_AW-1:0]  slot_nxt;
    logic                start_nxt;
    logic [SIG_BITS-1:0] active_nib;

    cas_slot_timer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BITS(SLOT_BITS)) timer_i (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
        .slot_o(slot_cur), .bit_o(bit_cur),
        .nxt_slot_o(slot_nxt), .nxt_start_o(start_nxt)
    );

    cas_nibble_store #(.DEPTH(NUM_SLOTS), .WIDTH(SIG_BITS)) store_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en_i(host_we_i), .wr_addr_i(host_addr_i), .wr_data_i(host_nib_i),
        .load_i(start_nxt), .load_addr_i(slot_nxt), .nib_o(active_nib)
    );

    cas_bit_driver #(.SLOT_BITS(SLOT_BITS), .SIG_BITS(SIG_BITS)) drv_i (
        .nib_i(active_nib), .bit_i(bit_cur),
        .sig_o(sig_o), .valid_o(sig_valid_o)
    );

    // R5: no stray bit outside the valid window.
    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_valid_o |-> !sig_o);

    // R5: the valid flag only covers the first SIG_BITS periods.
    p_valid_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sig_valid_o |-> (32'(bit_cur) < SIG_BITS));

    // R7: the nibble being sent cannot change within a slot.
    p_nibble_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_cur != '0) |-> $stable(active_nib));
endmodule

// File: tb/e1_cas_serializer_tb_top.sv
// Bench: arithmetic model of frame position and slot-start latching,
// checked on every cycle of full-frame sweeps.
module e1_cas_serializer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fs = 1'b0;
    logic       we = 1'b0;
    logic [4:0] addr = '0;
    logic [3:0] dat = '0;
    logic       sig, vld;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Reference model state.
    int       m_slot, m_bit;
    logic [3:0] m_store [32];
    logic [3:0] m_act;
    string    scen_tag = "";

    always #4 clk = ~clk;

    e1_cas_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start_i(fs),
        .host_we_i(we), .host_addr_i(addr), .host_nib_i(dat),
        .sig_o(sig), .sig_valid_o(vld)
    );

    function automatic logic [3:0] pat(int s, int k);
        return 4'((s * 5 + 9 + k * 3) % 16);
    endfunction

    task automatic tick(input logic f, input logic w, input int a, input logic [3:0] d);
        string tag;
        bit    wrapped, aligned;
        logic  ev, es;
        fs = f; we = w; addr = 5'(a); dat = d;
        aligned = (m_slot == 31 && m_bit == 7);
        @(posedge clk);
        wrapped = 0;
        if (!rst_n) begin
            m_slot = 0; m_bit = 0; m_act = '0;
            for (int i = 0; i < 32; i++) m_store[i] = '0;
        end else begin
            if (f) begin
                m_slot = 0; m_bit = 0;
            end else if (m_bit == 7) begin
                m_bit = 0;
                if (m_slot == 31) begin m_slot = 0; wrapped = 1; end
                else m_slot = m_slot + 1;
            end else m_bit = m_bit + 1;
            if (m_bit == 0) m_act = m_store[m_slot];
            if (w) m_store[a] = d;
        end
        @(negedge clk);
        fs = 0; we = 0;
        ev = (m_bit < 4);
        es = ev ? m_act[3 - m_bit] : 1'b0;
        if (!rst_n) tag = "R1";
        else if (f) tag = aligned ? "R3" : "R9";
        else if (wrapped) tag = "R2";
        else if (scen_tag != "") tag = scen_tag;
        else if (ev && (m_slot == 0 || m_slot == 16)) tag = "R6";
        else if (ev) tag = "R4";
        else tag = "R5";
        checks++;
        if (sig !== es || vld !== ev) begin
            failures++;
            $display("FAIL %s slot=%0d bit=%0d sig/valid actual=%b/%b expected=%b/%b",
                     tag, m_slot, m_bit, sig, vld, es, ev);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0, '0);
    endtask

    initial begin
        m_slot = 0; m_bit = 0; m_act = '0;
        for (int i = 0; i < 32; i++) m_store[i] = '0;
        @(negedge clk);
        // R1: reset state.
        for (int i = 0; i < 3; i++) tick(0, 0, 0, '0);
        rst_n = 1'b1;
        // Fill the table while running.
        for (int s = 0; s < 32; s++) tick(0, 1, s, pat(s, 0));
        // R9: mid-frame alignment, then two whole frames (R2, R4, R5, R6).
        tick(1, 0, 0, '0);
        run(512);
        // R3: pulse on the natural boundary.
        while (!(m_slot == 31 && m_bit == 7)) tick(0, 0, 0, '0);
        tick(1, 0, 0, '0);
        run(256);
        // R8: repeated frames without writes.
        scen_tag = "R8";
        run(512);
        // R7: write mid-nibble, and write on a slot-start edge.
        scen_tag = "R7";
        while (!(m_slot == 5 && m_bit == 1)) tick(0, 0, 0, '0);
        tick(0, 1, 5, ~m_store[5]);
        while (!(m_slot == 8 && m_bit == 7)) tick(0, 0, 0, '0);
        tick(0, 1, 9, ~m_store[9]);
        tick(0, 1, 9, 4'ha);
        tick(0, 1, 0, 4'hf);
        tick(0, 1, 16, 4'h9);
        run(600);
        scen_tag = "";
        // Free run with scattered writes and a second mid-frame pulse.
        for (int i = 0; i < 1200; i++) begin
            if (i == 700) tick(1, 0, 0, '0);
            else if (i % 37 == 0) tick(0, 1, (i / 37) % 32, pat(i / 37, 2));
            else tick(0, 0, 0, '0);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule